// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block opens only when three input values arrive, one per strobe, in the order set by three stored combination words. A value bus is sampled together with a single-cycle new-value strobe on the rising clock edge. A datapath keeps the three words. It uses a one-hot select to pick the word for the current step and compares it with the sampled value. A small control machine moves one step for each accepted strobe. The first wrong value sends it into a trapped error state. After all three matches it stays open.

The state encoding is the output decoding. The low three state bits are the word select, and the top bit is the open output. Software or a parent block loads the words through a write port while reset is held. Any later attempt to rewrite them is dropped.

Top module: `seq_lock`

## Requirements
- R1: With `rst` high at a rising edge, the machine enters the first step (`isOpen`=0, `muxSel`=3'b001), whatever `keyValid`, `keyValue` and the previous state are.
- R2: In any of the three step states, a cycle with `keyValid` low leaves `muxSel` and `isOpen` unchanged.
- R3: In a step state, a strobe whose value equals the selected word advances exactly one step: `muxSel` goes 001→010→100, and after the third match `isOpen`=1 with `muxSel`=000.
- R4: In a step state, a strobe whose value differs from the selected word moves to the error state (`isOpen`=0, `muxSel`=000).
- R5: Open and error states are left only by reset; strobes and values have no effect on them.
- R6: The state is one-hot or zero. The step encodings are 0001, 0010 and 0100, open is 1000 and error is 0000. `muxSel` is state bits [2:0] and `isOpen` is state bit 3.
- R7: With `cfgWrEn` high at a rising edge while `rst` is high, index 0, 1 or 2 writes `cfgWrData` into the first, second or third word. Index 3 writes nothing, and writes with `rst` low are ignored.
- R8: Inputs are sampled at the rising edge and the outputs change right after it. A strobe held high for several cycles counts as one entry per cycle and is compared against the word of the step current in that cycle.
- R9: The comparison covers all `W` bits of the value, so values that differ in any single bit, including the top one, do not match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also gates word writes |
| cfgWrEn | input | 1 | Combination word write enable |
| cfgWrIdx | input | 2 | Word index for a write (0..2 valid) |
| cfgWrData | input | W | Word value to store |
| keyValid | input | 1 | New-value strobe |
| keyValue | input | W | Entered value |
| isOpen | output | 1 | 1 when unlocked |
| muxSel | output | 3 | One-hot word select of the current step, zero when done |

## Verification
The bench builds the lock with `W`=3, so every value a digit can take fits in a short sweep. For eight different combinations, at each of the three positions, all eight candidate values are tried. This covers every early match and every mismatch, including those that differ only in the top bit. Each attempt then finishes the sequence and strikes the terminal state with further strobes. Idle gaps, strobes held high, reset with a strobe present, and writes outside reset or to index 3 are mixed into the same sweep.

// File: rtl/lock_pkg.sv
package lock_pkg;

  localparam int NumSteps = 3;
  localparam int StateW   = NumSteps + 1;

  typedef enum logic [StateW-1:0] {
    ST_ERR  = 4'b0000,
    ST_S1   = 4'b0001,
    ST_S2   = 4'b0010,
    ST_S3   = 4'b0100,
    ST_OPEN = 4'b1000
  } lockState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NumSteps-1:0] wordSel;
  } lockCtrl_t;

endpackage

// File: rtl/lock_datapath.sv
module lock_datapath
  import lock_pkg::*;
#(
  parameter int W    = 4,
  parameter int IdxW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfgWrEn,
  input  logic [IdxW-1:0] cfgWrIdx,
  input  logic [W-1:0]    cfgWrData,
  input  logic [W-1:0]    keyValue,
  input  lockCtrl_t       ctrl,
  output logic            match
);

  logic [NumSteps-1:0][W-1:0] wordMem;
  logic [NumSteps-1:0][W-1:0] wordGated;
  logic [W-1:0]               selWord;

  for (genvar g = 0; g < NumSteps; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst && cfgWrEn && (cfgWrIdx == IdxW'(g))) begin
        wordMem[g] <= cfgWrData;
      end
    end
    assign wordGated[g] = wordMem[g] & {W{ctrl.wordSel[g]}};
  end

  always_comb begin
    selWord = '0;
    for (int i = 0; i < NumSteps; i++) begin
      selWord = selWord | wordGated[i];
    end
  end

  assign match = (|ctrl.wordSel) && (selWord == keyValue);

  // R6: control never selects two words at once
  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl.wordSel));

  // R7: stored words cannot change while reset is low
  p_word_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    cfgWrEn |=> $stable(wordMem));

endmodule

// File: rtl/lock_control.sv
module lock_control
  import lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      keyValid,
  input  logic      match,
  output lockCtrl_t ctrl,
  output logic      isOpen
);

  lockState_e curState;
  lockState_e nxtState;
  logic       inStep;

  assign inStep = |curState[NumSteps-1:0];

  always_comb begin
    nxtState = curState;
    if (inStep && keyValid) begin
      nxtState = match ? lockState_e'({curState[NumSteps-1:0], 1'b0}) : ST_ERR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curState <= ST_S1;
    end else begin
      curState <= nxtState;
    end
  end

  assign ctrl.wordSel = curState[NumSteps-1:0];
  assign isOpen       = curState[NumSteps];

  // R1: first cycle out of reset is the first step
  p_reset_first_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (curState == ST_S1));

  // R2: no strobe, no movement
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (inStep && !keyValid) |=> $stable(curState));

  // R3: a match moves one position up
  p_match_step_r3: assert property (@(posedge clk) disable iff (rst)
    (inStep && keyValid && match) |=> (curState == ($past(curState) << 1)));

  // R4: a miss traps in error
  p_miss_err_r4: assert property (@(posedge clk) disable iff (rst)
    (inStep && keyValid && !match) |=> (curState == ST_ERR));

  // R5: terminal states are absorbing
  p_terminal_r5: assert property (@(posedge clk) disable iff (rst)
    !inStep |=> $stable(curState));

  // R6: encoding stays one-hot or zero
  p_state_code_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(curState));

endmodule

// File: rtl/seq_lock.sv
module seq_lock
  import lock_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfgWrEn,
  input  logic [1:0]   cfgWrIdx,
  input  logic [W-1:0] cfgWrData,
  input  logic         keyValid,
  input  logic [W-1:0] keyValue,
  output logic         isOpen,
  output logic [2:0]   muxSel
);

  localparam int IdxW = $clog2(NumSteps + 1);

  lockCtrl_t ctrl;
  logic      match;

  lock_datapath #(.W(W), .IdxW(IdxW)) datapath_i (
    .clk       (clk),
    .rst       (rst),
    .cfgWrEn   (cfgWrEn),
    .cfgWrIdx  (cfgWrIdx),
    .cfgWrData (cfgWrData),
    .keyValue  (keyValue),
    .ctrl      (ctrl),
    .match     (match)
  );

  lock_control control_i (
    .clk      (clk),
    .rst      (rst),
    .keyValid (keyValid),
    .match    (match),
    .ctrl     (ctrl),
    .isOpen   (isOpen)
  );

  assign muxSel = ctrl.wordSel;

endmodule

// File: tb/seq_lock_tb_top.sv
module seq_lock_tb_top;

  localparam int ClkPeriod = 10;
  localparam int W         = 3;
  localparam int NVal      = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfgWrEn = 1'b0;
  logic [1:0]   cfgWrIdx = '0;
  logic [W-1:0] cfgWrData = '0;
  logic         keyValid = 1'b0;
  logic [W-1:0] keyValue = '0;
  logic         isOpen;
  logic [2:0]   muxSel;

  int nCmp = 0;
  int nBad = 0;
  int mStep = 0;   // 0..2 step, 3 open, 4 error
  bit done = 1'b0;
  logic [W-1:0] code [3];

  always #(ClkPeriod/2) clk = ~clk;

  seq_lock #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
    .cfgWrData(cfgWrData), .keyValid(keyValid), .keyValue(keyValue),
    .isOpen(isOpen), .muxSel(muxSel)
  );

  task automatic chk(input string req);
    logic [2:0] eSel;
    logic       eOpen;
    eSel  = (mStep < 3) ? 3'(1 << mStep) : 3'b000;
    eOpen = (mStep == 3);
    nCmp++;
    if (muxSel !== eSel || isOpen !== eOpen) begin
      nBad++;
      $display("FAIL %s: got open=%b sel=%b, expected open=%b sel=%b",
               req, isOpen, muxSel, eOpen, eSel);
    end
  endtask

  // one clock with given strobe/value; model update and check
  task automatic cyc(input bit v, input logic [W-1:0] val, input string req);
    keyValid = v;
    keyValue = val;
    @(posedge clk);
    @(negedge clk);
    keyValid = 1'b0;
    if (v && mStep < 3) mStep = (val == code[mStep]) ? mStep + 1 : 4;
    chk(req);
  endtask

  task automatic loadReset(input logic [W-1:0] junk);
    rst = 1'b1;
    keyValid = 1'b1;
    keyValue = junk;
    for (int i = 0; i < 3; i++) begin
      cfgWrEn = 1'b1; cfgWrIdx = 2'(i); cfgWrData = code[i];
      @(posedge clk); @(negedge clk);
    end
    cfgWrEn = 1'b1; cfgWrIdx = 2'd3; cfgWrData = ~code[0];  // R7 idx 3 dropped
    @(posedge clk); @(negedge clk);
    cfgWrEn = 1'b0;
    keyValid = 1'b0;
    mStep = 0;
    chk("R1");
    rst = 1'b0;
  endtask

  initial begin
    #(ClkPeriod * 150000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      code[0] = W'(c);
      code[1] = W'(c * 3 + 1);
      code[2] = W'(c * 5 + 2);
      for (int p = 0; p < 3; p++) begin
        for (int v = 0; v < NVal; v++) begin
          loadReset(W'(v));
          if (v == 0) begin
            // R7: write outside reset must not alter word 0
            cfgWrEn = 1'b1; cfgWrIdx = 2'd0; cfgWrData = code[0] ^ 3'b100;
            cyc(1'b0, '0, "R7 R2");
            cfgWrEn = 1'b0;
          end
          for (int k = 0; k < p; k++) begin
            cyc(1'b0, code[k] ^ 3'b111, "R2");
            cyc(1'b1, code[k], "R3 R6");
          end
          cyc(1'b1, W'(v), (W'(v) == code[p]) ? "R3 R9" : "R4 R9");
          for (int k = p + 1; k < 3; k++) cyc(1'b1, code[k], "R3 R4 R6");
          cyc(1'b1, code[0], "R5");
          cyc(1'b1, code[1], "R5");
          cyc(1'b0, code[2], "R5");
        end
      end
      // reset from the terminal state with a live strobe
      loadReset(code[0]);
    end

    // R8: held strobe, one step per cycle
    code[0] = 3'd5; code[1] = 3'd5; code[2] = 3'd6;
    loadReset(3'd5);
    cyc(1'b1, 3'd5, "R8");
    keyValid = 1'b1; keyValue = 3'd5;
    @(posedge clk); @(negedge clk);
    mStep = 2;
    chk("R8");
    cyc(1'b1, 3'd5, "R8 R4");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule